// File: doc/BRIEF.md
# Master Clock Selector and Prescaler

This block builds the chip's master clock and processor clock from one of three free-running input clocks: a slow clock, a main clock and a PLL output. A selection code picks the source. A power-of-two prescaler divides that source to form the processor clock. A second divider then divides the processor clock by 1, 2 or 4 to form the master clock, so the processor clock never runs slower than the master clock. The source change is glitch-free. Each input clock has its own enable stage, clocked on that clock's falling edge. The old source is released on its own low phase, and the new one is taken on its own low phase.

Configuration arrives through a single-cycle write strobe in the bus clock domain. Every write lowers a ready flag. The flag rises again only after two things have happened: the source handover is finished, and the write request has passed a two-edge synchronizer clocked by the new output clock. The ready acknowledge then returns to the bus domain through a second synchronizer. When the interrupt enable input is high, each rise of the ready flag gives a one-cycle interrupt pulse.

Top module: `mclk_gen`

## Requirements
- R1: After reset the slow clock is selected, prescaler and divider are both 1, the ready flag reads 1 and the interrupt output reads 0.
- R2: Source code 0 selects the slow clock, 1 the main clock and 2 the PLL clock. Code 3 is reserved and selects the slow clock.
- R3: Prescaler codes 0 to 6 make the processor clock period 1, 2, 4, 8, 16, 32 or 64 times the source period. Code 7 is reserved and gives a factor of 1.
- R4: Divider codes 0, 1 and 2 make the master clock period 1, 2 or 4 times the processor clock period. Code 3 is reserved and gives a ratio of 1.
- R5: In the bus cycle that follows a write, the ready flag reads 0.
- R6: The ready flag returns to 1 only after the source handover and the new-domain synchronizer have both completed. From that point the master clock runs at the newly configured period. It never rises in the cycle right after a write.
- R7: When the interrupt enable input is high, each rise of the ready flag gives an interrupt pulse exactly one bus cycle wide. When it is low, no pulse appears.
- R8: At most one source enable is active at any time. Once settled, the master clock high time is exactly half its period, so no runt pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Clock for the configuration write interface |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_slow | input | 1 | Slow input clock, source code 0 |
| clk_main | input | 1 | Main input clock, source code 1 |
| clk_pll | input | 1 | PLL input clock, source code 2 |
| cfg_wr | input | 1 | One-cycle write strobe for the configuration fields |
| cfg_src | input | 2 | Source selection code |
| cfg_pres | input | 3 | Prescaler code |
| cfg_mdiv | input | 2 | Master clock divider code |
| irq_en | input | 1 | Enables the interrupt pulse on a rising ready flag |
| mck_rdy | output | 1 | Ready flag: the configured master clock is running |
| mck_irq | output | 1 | One-cycle interrupt pulse, bus clock domain |
| pck | output | 1 | Processor clock |
| mck | output | 1 | Master clock |

## Verification
The assertions rely on three properties of the inputs. A new write is issued only while the ready flag is high. The three source clocks run continuously. The configuration codes hold steady between writes. If a second write arrived while an acknowledge was still in flight, the request and acknowledge toggles could meet early and the ready checks would no longer apply. For this reason the stimulus waits for the ready flag after every write before it measures the clocks or issues the next write. The source clocks toggle from reset onward, at phases offset from the bus clock.

// File: rtl/mclk_pkg.sv
`timescale 1ns/1ps
package mclk_pkg;

  localparam int SRC_W      = 2;
  localparam int PRES_W     = 3;
  localparam int MDIV_W     = 2;
  localparam int MAX_PSHIFT = 6;
  localparam int MAX_MSHIFT = 2;
  localparam int SHIFT_W    = 4;

  typedef enum logic [SRC_W-1:0] {
    SRC_SLOW = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_RSVD = 2'd3
  } src_code_e;

  // Prescaler code to log2 of the division factor; the reserved code divides by 1.
  function automatic logic [SHIFT_W-1:0] pres_shift(input logic [PRES_W-1:0] code);
    if (code > PRES_W'(MAX_PSHIFT)) return '0;
    return SHIFT_W'(code);
  endfunction

  // Divider code to log2 of the processor-to-master ratio; the reserved code gives 1.
  function automatic logic [SHIFT_W-1:0] mdiv_shift(input logic [MDIV_W-1:0] code);
    if (code > MDIV_W'(MAX_MSHIFT)) return '0;
    return SHIFT_W'(code);
  endfunction

  // Source code to mux index; a code beyond the last source falls back to slow.
  function automatic logic [SRC_W-1:0] src_index(input logic [SRC_W-1:0] code, input int nsrc);
    if (int'(code) >= nsrc) return SRC_SLOW;
    return code;
  endfunction

endpackage

// File: rtl/mclk_cfg_regs.sv
`timescale 1ns/1ps
module mclk_cfg_regs
  import mclk_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [SRC_W-1:0]  src_code,
  input  logic [PRES_W-1:0] pres_code,
  input  logic [MDIV_W-1:0] mdiv_code,
  input  logic              irq_en,
  input  logic              ack_tgl,
  output logic [SRC_W-1:0]  sel_idx,
  output logic [PRES_W-1:0] pres_q,
  output logic [MDIV_W-1:0] mdiv_q,
  output logic              req_tgl,
  output logic              rdy,
  output logic              irq
);

  logic [SRC_W-1:0] src_q;
  logic             ack_s1, ack_s2;
  logic             rdy_d;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= SRC_SLOW;
      pres_q  <= '0;
      mdiv_q  <= '0;
      req_tgl <= 1'b0;
      ack_s1  <= 1'b0;
      ack_s2  <= 1'b0;
      rdy_d   <= 1'b1;
      irq     <= 1'b0;
    end else begin
      ack_s1 <= ack_tgl;
      ack_s2 <= ack_s1;
      rdy_d  <= rdy;
      irq    <= irq_en && rdy && !rdy_d;
      if (wr) begin
        src_q   <= src_code;
        pres_q  <= pres_code;
        mdiv_q  <= mdiv_code;
        req_tgl <= ~req_tgl;
      end
    end
  end

  assign sel_idx = src_index(src_q, NSRC);
  assign rdy     = (ack_s2 == req_tgl);

  a_r5_wr_clears_rdy: assert property (@(posedge bus_clk) disable iff (!rst_n)
    wr |=> !rdy);

  a_r6_no_early_rdy: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $rose(rdy) |-> !$past(wr));

  a_r7_irq_single: assert property (@(posedge bus_clk) disable iff (!rst_n)
    irq |=> !irq);

endmodule

// File: rtl/mclk_src_mux.sv
`timescale 1ns/1ps
module mclk_src_mux
  import mclk_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0]  clk_in,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] sel_idx,
  output logic             clk_out,
  output logic             sw_done
);

  logic [NSRC-1:0] en;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic want, st1, st2;
    // A source may take over only when every other source has let go.
    always_comb want = (sel_idx == SRC_W'(i)) && ((en & ~(NSRC'(1) << i)) == '0);

    always_ff @(negedge clk_in[i] or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= (i == 0);
        st2 <= (i == 0);
      end else begin
        st1 <= want;
        st2 <= st1;
      end
    end
    assign en[i] = st2;
  end

  assign clk_out = |(clk_in & en);
  assign sw_done = en[sel_idx];

  a_r8_onehot_en: assert property (@(posedge clk_out) disable iff (!rst_n)
    $onehot0(en));

endmodule

// File: rtl/mclk_divider.sv
`timescale 1ns/1ps
module mclk_divider
  import mclk_pkg::*;
#(
  parameter int CNT_W = MAX_PSHIFT + MAX_MSHIFT
) (
  input  logic              clk_sel,
  input  logic              rst_n,
  input  logic [PRES_W-1:0] pres_code,
  input  logic [MDIV_W-1:0] mdiv_code,
  input  logic              req_tgl,
  input  logic              sw_done,
  output logic              pck,
  output logic              mck,
  output logic              ack_tgl
);

  localparam int IDX_W = $clog2(CNT_W);

  logic [CNT_W-1:0]   cnt;
  logic [PRES_W-1:0]  pres_l;
  logic [MDIV_W-1:0]  mdiv_l;
  logic               s1, s2;
  logic [SHIFT_W-1:0] p_sh, t_sh;
  logic [IDX_W-1:0]   p_idx, t_idx;

  always_ff @(posedge clk_sel or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pres_l <= '0;
      mdiv_l <= '0;
      s1     <= 1'b0;
      s2     <= 1'b0;
    end else begin
      cnt    <= cnt + 1'b1;
      pres_l <= pres_code;
      mdiv_l <= mdiv_code;
      if (sw_done) s1 <= req_tgl;
      s2 <= s1;
    end
  end

  assign p_sh  = pres_shift(pres_l);
  assign t_sh  = p_sh + mdiv_shift(mdiv_l);
  assign p_idx = IDX_W'(p_sh - 4'd1);
  assign t_idx = IDX_W'(t_sh - 4'd1);

  // Counter bit k toggles every 2^k edges, so its period is 2^(k+1) source periods.
  assign pck     = (p_sh == '0) ? clk_sel : cnt[p_idx];
  assign mck     = (t_sh == '0) ? clk_sel : cnt[t_idx];
  assign ack_tgl = s2;

  a_r6_ack_after_switch: assert property (@(posedge clk_sel) disable iff (!rst_n)
    (s1 != $past(s1)) |-> $past(sw_done));

endmodule

// File: rtl/mclk_gen.sv
`timescale 1ns/1ps
module mclk_gen
  import mclk_pkg::*;
(
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              clk_slow,
  input  logic              clk_main,
  input  logic              clk_pll,
  input  logic              cfg_wr,
  input  logic [SRC_W-1:0]  cfg_src,
  input  logic [PRES_W-1:0] cfg_pres,
  input  logic [MDIV_W-1:0] cfg_mdiv,
  input  logic              irq_en,
  output logic              mck_rdy,
  output logic              mck_irq,
  output logic              pck,
  output logic              mck
);

  localparam int NSRC = 3;

  logic [SRC_W-1:0]  sel_idx;
  logic [PRES_W-1:0] pres_q;
  logic [MDIV_W-1:0] mdiv_q;
  logic              req_tgl, ack_tgl, sw_done, clk_sel;

  mclk_cfg_regs #(.NSRC(NSRC)) u_regs (
    .bus_clk(bus_clk), .rst_n(rst_n), .wr(cfg_wr),
    .src_code(cfg_src), .pres_code(cfg_pres), .mdiv_code(cfg_mdiv),
    .irq_en(irq_en), .ack_tgl(ack_tgl),
    .sel_idx(sel_idx), .pres_q(pres_q), .mdiv_q(mdiv_q),
    .req_tgl(req_tgl), .rdy(mck_rdy), .irq(mck_irq)
  );

  mclk_src_mux #(.NSRC(NSRC)) u_mux (
    .clk_in({clk_pll, clk_main, clk_slow}), .rst_n(rst_n),
    .sel_idx(sel_idx), .clk_out(clk_sel), .sw_done(sw_done)
  );

  mclk_divider #(.CNT_W(MAX_PSHIFT + MAX_MSHIFT)) u_div (
    .clk_sel(clk_sel), .rst_n(rst_n),
    .pres_code(pres_q), .mdiv_code(mdiv_q),
    .req_tgl(req_tgl), .sw_done(sw_done),
    .pck(pck), .mck(mck), .ack_tgl(ack_tgl)
  );

endmodule

// File: tb/mclk_gen_tb_top.sv
`timescale 1ns/1ps
module mclk_gen_tb_top;

  logic bus_clk = 1'b0, clk_slow = 1'b0, clk_main = 1'b0, clk_pll = 1'b0;
  logic rst_n = 1'b0, cfg_wr = 1'b0, irq_en = 1'b0;
  logic [1:0] cfg_src = '0;
  logic [2:0] cfg_pres = '0;
  logic [1:0] cfg_mdiv = '0;
  logic mck_rdy, mck_irq, pck, mck;

  int n_chk = 0, n_fail = 0, irq_cnt = 0;
  bit done = 0;

  mclk_gen dut_i (
    .bus_clk(bus_clk), .rst_n(rst_n), .clk_slow(clk_slow), .clk_main(clk_main),
    .clk_pll(clk_pll), .cfg_wr(cfg_wr), .cfg_src(cfg_src), .cfg_pres(cfg_pres),
    .cfg_mdiv(cfg_mdiv), .irq_en(irq_en), .mck_rdy(mck_rdy), .mck_irq(mck_irq),
    .pck(pck), .mck(mck)
  );

  // Source periods: slow 80 ns, main 40 ns, PLL 20 ns, offset from the 100 MHz bus clock.
  always #5 bus_clk = ~bus_clk;
  initial begin #3; forever #40 clk_slow = ~clk_slow; end
  initial begin #1; forever #20 clk_main = ~clk_main; end
  initial begin #2; forever #10 clk_pll  = ~clk_pll;  end

  always @(negedge bus_clk) if (mck_irq) irq_cnt++;

  localparam int NV = 7;
  localparam int V_SRC [NV] = '{1, 2, 0, 2, 1, 2, 3};
  localparam int V_PRES[NV] = '{0, 1, 2, 6, 7, 3, 0};
  localparam int V_MDIV[NV] = '{0, 1, 2, 0, 3, 2, 0};
  localparam int V_IRQ [NV] = '{1, 1, 0, 1, 1, 0, 1};
  localparam int V_PCK [NV] = '{40, 40, 320, 1280, 40, 160, 80};
  localparam int V_MCK [NV] = '{40, 80, 1280, 1280, 40, 640, 80};

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output longint mp, output longint mh, output longint pp);
    realtime t0, t1, t2, p0, p1;
    repeat (2) @(posedge mck);
    @(posedge mck); t0 = $realtime;
    @(negedge mck); t1 = $realtime;
    @(posedge mck); t2 = $realtime;
    @(posedge pck); p0 = $realtime;
    @(posedge pck); p1 = $realtime;
    mp = longint'(t2 - t0);
    mh = longint'(t1 - t0);
    pp = longint'(p1 - p0);
  endtask

  task automatic wait_rdy(output bit seen);
    seen = 0;
    for (int k = 0; k < 5000 && !seen; k++) begin
      @(negedge bus_clk);
      if (mck_rdy) seen = 1;
    end
  endtask

  initial begin
    longint mp, mh, pp;
    int irq_before;
    bit seen;
    repeat (20) @(negedge bus_clk);
    // R1: state held during and just after reset
    chk("R1 rdy in reset", longint'(mck_rdy), 1);
    rst_n = 1'b1;
    @(negedge bus_clk);
    chk("R1 rdy after reset", longint'(mck_rdy), 1);
    chk("R1 irq after reset", longint'(mck_irq), 0);
    measure(mp, mh, pp);
    chk("R1 mck period slow div1", mp, 80);
    chk("R1 pck period slow div1", pp, 80);
    chk("R8 mck high half", mh, 40);

    for (int v = 0; v < NV; v++) begin
      irq_before = irq_cnt;
      @(negedge bus_clk);
      cfg_wr = 1'b1;
      cfg_src = 2'(V_SRC[v]);
      cfg_pres = 3'(V_PRES[v]);
      cfg_mdiv = 2'(V_MDIV[v]);
      irq_en = 1'(V_IRQ[v]);
      @(negedge bus_clk);
      cfg_wr = 1'b0;
      chk("R5 rdy low after write", longint'(mck_rdy), 0);
      wait_rdy(seen);
      chk("R6 rdy returns", longint'(seen), 1);
      repeat (3) @(negedge bus_clk);
      chk("R7 irq pulses", longint'(irq_cnt - irq_before), longint'(V_IRQ[v]));
      measure(mp, mh, pp);
      // R2 R3: processor clock from the selected source and prescaler
      chk("R3 pck period", pp, longint'(V_PCK[v]));
      // R4 R6: master clock already at its new period
      chk("R4 mck period", mp, longint'(V_MCK[v]));
      chk("R8 mck high half", mh, mp / 2);
    end

    // R2: reserved source code and slow source both give 80 ns, checked above; main re-selected.
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog expired act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule